// File: doc/BRIEF.md
# Programmable Color Space Converter

This block converts a stream of pixels from one color space to another, one pixel per cycle. Each pixel carries three 10-bit components, typically luma and two chroma samples. Each of the three outputs is formed by adding a signed offset to every input component and taking a dot product with one row of signed fixed-point coefficients. A signed constant is then added, and the result is rounded and clamped to the 10-bit output range. When the enable bit is clear, the block passes pixels through unchanged with the same latency.

Software loads twelve 32-bit coefficient words and an enable bit through a single-register write port. The writes go into a staging copy. The copy the datapath uses changes only on a frame-start pulse, so a frame never mixes two coefficient sets. The staging logic is a two-state machine. SHD_CLEAN means staging equals the active copy. SHD_DIRTY means staging holds writes that are not yet applied. The transitions are:

- CLEAN to DIRTY on any register write.
- DIRTY to CLEAN on a frame-start with no write in that cycle.
- DIRTY stays DIRTY on a frame-start that coincides with a write.

The active copy loads on frame-start only in state DIRTY. Frame-start is meant to arrive in blanking, after the three-stage pipeline has drained. Input order YVU instead of YUV is handled only by exchanging coefficient columns 1 and 2.

Top module: `csc_top`

## Requirements
- R1: After reset, out_valid is 0, all outputs are 0, all coefficient words are 0 and the enable bit is 0, so pixels pass through unchanged.
- R2: out_valid equals in_valid delayed by exactly 3 clock cycles, with every accepted pixel producing exactly one output and no backpressure.
- R3: With the active enable bit 0, each output component equals the corresponding input component from 3 cycles earlier, whatever the coefficients.
- R4: With enable 1, output r = sum over c of K[4r+c]*(in_c + d_c) + C_r. Address 4r+c (c = 0..2) holds coefficient K for row r and column c. Address 4r+3 holds the signed offset d_r in bits [31:16] and the signed constant C_r in bits [15:0]. d_r is applied to input component r.
- R5: Coefficients are 32-bit two's complement with 17 fractional bits (0x00020000 is 1.0). The full-precision sum is rounded half up at the fraction boundary, so +0.5 rounds to 1 and -0.5+2 rounds to 2.
- R6: The rounded result is clamped to 0..1023: negative results give 0 and results above 1023 give 1023.
- R7: A write changes only the staging copy. Pixels keep using the previous coefficients and enable until a frame_start pulse.
- R8: On frame_start the staging values (coefficients and enable) become active for the following pixels. A write in the same cycle as frame_start is not part of that update and waits for the next frame_start.
- R9: YVU input order is converted correctly by the same datapath when coefficient columns 1 and 2 are exchanged.
- R10: Address 12 bit 0 is the enable bit. Writes to addresses 13 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Applies staged registers |
| in_valid | input | 1 | Input pixel valid |
| in_c0 | input | 10 | Input component 0 (luma) |
| in_c1 | input | 10 | Input component 1 |
| in_c2 | input | 10 | Input component 2 |
| out_valid | output | 1 | Output pixel valid |
| out_c0 | output | 10 | Output component 0 |
| out_c1 | output | 10 | Output component 1 |
| out_c2 | output | 10 | Output component 2 |

## Verification
The hardest case to reach from the ports is a register update that is pending but not yet applied. One example is a write that lands in the same cycle as frame_start, which must stay staged while the previous set keeps converting pixels. The stimulus creates this with directed sequences: a write followed by pixels with no frame_start, a write coinciding with frame_start, and then a second frame_start. Rounding ties and both clamp limits are hit with hand-picked coefficients. Seeded random coefficient sets and pixel bursts with idle gaps cover the general arithmetic and the latency.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int PIX_W      = 10;
    localparam int COEF_W     = 32;
    localparam int FRAC_W     = 17;
    localparam int HALF_W     = COEF_W / 2;
    localparam int NROW       = 3;
    localparam int ROW_STRIDE = NROW + 1;
    localparam int NREG       = NROW * ROW_STRIDE;
    localparam int ADDR_W     = 4;
    localparam int EN_ADDR    = NREG;
    localparam int OPND_W     = (((PIX_W + 1) > HALF_W) ? (PIX_W + 1) : HALF_W) + 1;
    localparam int PROD_W     = COEF_W + OPND_W;
    localparam int ACC_W      = PROD_W + 3;
    localparam int PIX_MAX    = (1 << PIX_W) - 1;
    localparam int ROUND_HALF = 1 << (FRAC_W - 1);

    typedef enum logic {
        SHD_CLEAN = 1'b0,
        SHD_DIRTY = 1'b1
    } shd_state_t;
endpackage

// File: rtl/csc_shadow_regs.sv
module csc_shadow_regs
    import csc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_we,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [COEF_W-1:0]              reg_wdata,
    input  logic                           frame_start,
    output logic [NREG-1:0][COEF_W-1:0]    act_coef,
    output logic                           act_en
);
    logic [NREG-1:0][COEF_W-1:0] stg_coef;
    logic                        stg_en;
    shd_state_t                  state_q, state_d;

    // staging copy, written by software at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_coef <= '0;
            stg_en   <= 1'b0;
        end else if (reg_we) begin
            for (int i = 0; i < NREG; i++) begin
                if (reg_addr == ADDR_W'(i)) stg_coef[i] <= reg_wdata;
            end
            if (reg_addr == ADDR_W'(EN_ADDR)) stg_en <= reg_wdata[0];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SHD_CLEAN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SHD_CLEAN: if (reg_we) state_d = SHD_DIRTY;
            SHD_DIRTY: if (frame_start && !reg_we) state_d = SHD_CLEAN;
            default:   state_d = SHD_CLEAN;
        endcase
    end

    // outputs: active copy loads on frame start while updates are pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_coef <= '0;
            act_en   <= 1'b0;
        end else if (frame_start && state_q == SHD_DIRTY) begin
            act_coef <= stg_coef;
            act_en   <= stg_en;
        end
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> ($stable(act_coef) && $stable(act_en)));

    assert_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (act_coef == $past(stg_coef) && act_en == $past(stg_en)));

    assert_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (state_q == SHD_DIRTY));
endmodule

// File: rtl/csc_row.sv
module csc_row
    import csc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NROW-1:0][OPND_W-1:0]  opnd_s1,
    input  logic [NROW-1:0][COEF_W-1:0]  coef,
    input  logic [HALF_W-1:0]            cst,
    input  logic                         en_s1,
    input  logic [PIX_W-1:0]             raw_s1,
    output logic [PIX_W-1:0]             pix_out
);
    logic [NROW-1:0][PROD_W-1:0] prod_s2;
    logic                        en_s2;
    logic [PIX_W-1:0]            raw_s2;
    logic signed [ACC_W-1:0]     acc;
    logic signed [ACC_W-1:0]     quo;
    logic [PIX_W-1:0]            sat;

    // stage 2: full-precision products
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_s2 <= '0;
            en_s2   <= 1'b0;
            raw_s2  <= '0;
        end else begin
            for (int c = 0; c < NROW; c++) begin
                prod_s2[c] <= PROD_W'($signed(coef[c])) * PROD_W'($signed(opnd_s1[c]));
            end
            en_s2  <= en_s1;
            raw_s2 <= raw_s1;
        end
    end

    // stage 3: sum, constant, round half up, clamp
    always_comb begin
        acc = ACC_W'($signed(cst)) <<< FRAC_W;
        for (int c = 0; c < NROW; c++) begin
            acc = acc + ACC_W'($signed(prod_s2[c]));
        end
        acc = acc + ACC_W'(ROUND_HALF);
        quo = acc >>> FRAC_W;
        if (quo < 0)
            sat = '0;
        else if (quo > $signed(ACC_W'(PIX_MAX)))
            sat = PIX_W'(PIX_MAX);
        else
            sat = quo[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pix_out <= '0;
        else        pix_out <= en_s2 ? sat : raw_s2;
    end
endmodule

// File: rtl/csc_top.sv
module csc_top
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [COEF_W-1:0] reg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_c0,
    input  logic [PIX_W-1:0]  in_c1,
    input  logic [PIX_W-1:0]  in_c2,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_c0,
    output logic [PIX_W-1:0]  out_c1,
    output logic [PIX_W-1:0]  out_c2
);
    logic [NREG-1:0][COEF_W-1:0] act_coef;
    logic                        act_en;
    logic [NROW-1:0][PIX_W-1:0]  pix_in;
    logic [NROW-1:0][PIX_W-1:0]  pix_out;
    logic [NROW-1:0][OPND_W-1:0] opnd_s1;
    logic [NROW-1:0][PIX_W-1:0]  raw_s1;
    logic                        en_s1;
    logic                        v_s1, v_s2;

    assign pix_in[0] = in_c0;
    assign pix_in[1] = in_c1;
    assign pix_in[2] = in_c2;

    csc_shadow_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .frame_start (frame_start),
        .act_coef    (act_coef),
        .act_en      (act_en)
    );

    // stage 1: offset correction per input component
    for (genvar c = 0; c < NROW; c++) begin : g_ofs
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                opnd_s1[c] <= '0;
                raw_s1[c]  <= '0;
            end else begin
                opnd_s1[c] <= OPND_W'($signed({1'b0, pix_in[c]}))
                            + OPND_W'($signed(act_coef[c*ROW_STRIDE+NROW][COEF_W-1 -: HALF_W]));
                raw_s1[c]  <= pix_in[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_s1     <= 1'b0;
            v_s1      <= 1'b0;
            v_s2      <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            en_s1     <= act_en;
            v_s1      <= in_valid;
            v_s2      <= v_s1;
            out_valid <= v_s2;
        end
    end

    for (genvar r = 0; r < NROW; r++) begin : g_row
        csc_row u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .opnd_s1 (opnd_s1),
            .coef    (act_coef[r*ROW_STRIDE +: NROW]),
            .cst     (act_coef[r*ROW_STRIDE+NROW][HALF_W-1:0]),
            .en_s1   (en_s1),
            .raw_s1  (raw_s1[r]),
            .pix_out (pix_out[r])
        );
    end

    assign out_c0 = pix_out[0];
    assign out_c1 = pix_out[1];
    assign out_c2 = pix_out[2];

    // cycles since reset, so history checks never reach into reset
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)               warm_q <= '0;
        else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && out_valid && !$past(act_en, 3)) |->
        (out_c0 == $past(in_c0, 3) && out_c1 == $past(in_c1, 3) && out_c2 == $past(in_c2, 3)));
endmodule

// File: tb/csc_top_tb.sv
`timescale 1ns/1ps
module csc_top_tb;
    import csc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [COEF_W-1:0] reg_wdata = '0;
    logic              frame_start = 1'b0;
    logic              in_valid = 1'b0;
    logic [PIX_W-1:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic              out_valid;
    logic [PIX_W-1:0]  out_c0, out_c1, out_c2;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] stg_m [NREG];
    logic [31:0] act_m [NREG];
    bit          stg_en_m, act_en_m;

    int    q_cyc[$];
    int    q_v0[$], q_v1[$], q_v2[$];
    string q_tag[$];

    csc_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .in_valid(in_valid),
        .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2), .out_valid(out_valid),
        .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ref_out(input int r, input int x0, input int x1, input int x2);
        longint a[3];
        longint s;
        int px[3];
        px[0] = x0; px[1] = x1; px[2] = x2;
        if (!act_en_m) return px[r];
        for (int c = 0; c < 3; c++) a[c] = longint'(px[c]) + longint'($signed(act_m[4*c+3][31:16]));
        s = longint'($signed(act_m[4*r+3][15:0])) * 131072;
        for (int c = 0; c < 3; c++) s = s + longint'($signed(act_m[4*r+c])) * a[c];
        s = s + 65536;
        s = s >>> 17;
        if (s < 0) return 0;
        if (s > 1023) return 1023;
        return int'(s);
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            reg_we = 0; frame_start = 0; in_valid = 0;
        end
    endtask

    task automatic model_write(input int a, input logic [31:0] d);
        if (a < NREG) stg_m[a] = d;
        else if (a == EN_ADDR) stg_en_m = d[0];
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a[ADDR_W-1:0]; reg_wdata = d;
        frame_start = 0; in_valid = 0;
        model_write(a, d);
    endtask

    task automatic frame();
        idle(4);
        @(negedge clk);
        reg_we = 0; frame_start = 1; in_valid = 0;
        for (int i = 0; i < NREG; i++) act_m[i] = stg_m[i];
        act_en_m = stg_en_m;
    endtask

    task automatic wr_frame(input int a, input logic [31:0] d);
        idle(4);
        @(negedge clk);
        reg_we = 1; reg_addr = a[ADDR_W-1:0]; reg_wdata = d;
        frame_start = 1; in_valid = 0;
        for (int i = 0; i < NREG; i++) act_m[i] = stg_m[i];
        act_en_m = stg_en_m;
        model_write(a, d);
    endtask

    task automatic px(input int x0, input int x1, input int x2, input string tag);
        @(negedge clk);
        reg_we = 0; frame_start = 0; in_valid = 1;
        in_c0 = x0[PIX_W-1:0]; in_c1 = x1[PIX_W-1:0]; in_c2 = x2[PIX_W-1:0];
        q_cyc.push_back(cyc + 3);
        q_v0.push_back(ref_out(0, x0, x1, x2));
        q_v1.push_back(ref_out(1, x0, x1, x2));
        q_v2.push_back(ref_out(2, x0, x1, x2));
        q_tag.push_back(tag);
    endtask

    task automatic load(input logic [31:0] t[NREG]);
        for (int i = 0; i < NREG; i++) wr(i, t[i]);
    endtask

    // output monitor: every expected pixel at its exact cycle, nothing else
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                checks++;
                if (!out_valid || out_c0 != q_v0[0][PIX_W-1:0] || out_c1 != q_v1[0][PIX_W-1:0]
                    || out_c2 != q_v2[0][PIX_W-1:0]) begin
                    failures++;
                    $display("FAIL %s cyc=%0d got v=%0d %0d/%0d/%0d exp v=1 %0d/%0d/%0d",
                             q_tag[0], cyc, out_valid, out_c0, out_c1, out_c2,
                             q_v0[0], q_v1[0], q_v2[0]);
                end
                void'(q_cyc.pop_front()); void'(q_v0.pop_front());
                void'(q_v1.pop_front()); void'(q_v2.pop_front()); void'(q_tag.pop_front());
            end else if (out_valid) begin
                checks++; failures++;
                $display("FAIL R2 unexpected out_valid cyc=%0d got 1 exp 0", cyc);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired got running exp finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] t[NREG];
        logic [31:0] sw[NREG];
        void'($urandom(32'd7321));
        for (int i = 0; i < NREG; i++) begin stg_m[i] = 0; act_m[i] = 0; end
        stg_en_m = 0; act_en_m = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_c0 !== 0 || out_c1 !== 0 || out_c2 !== 0) begin
            failures++;
            $display("FAIL R1 reset outputs got %0d %0d/%0d/%0d exp 0 0/0/0",
                     out_valid, out_c0, out_c1, out_c2);
        end
        px(100, 200, 300, "R1");
        px(1023, 0, 5, "R1");
        idle(4);

        // R3: random coefficients but enable cleared
        for (int i = 0; i < NREG; i++) t[i] = $urandom;
        load(t); wr(12, 0); frame();
        for (int k = 0; k < 8; k++) px($urandom_range(0, 1023), $urandom_range(0, 1023), $urandom_range(0, 1023), "R3");
        idle(4);

        // R4: identity, then limited-range offsets
        for (int i = 0; i < NREG; i++) t[i] = 0;
        t[0] = 32'h20000; t[5] = 32'h20000; t[10] = 32'h20000;
        load(t); wr(12, 1); frame();
        px(0, 0, 0, "R4"); px(1023, 512, 7, "R4");
        t[0] = 32'h2542A; t[1] = 0;            t[2] = 32'h3312A;  t[3] = 32'hFFC00000;
        t[4] = 32'h2542A; t[5] = 32'hFFFF376B; t[6] = 32'hFFFE5FC3; t[7] = 32'hFE000000;
        t[8] = 32'h2542A; t[9] = 32'h408D2;    t[10] = 0;         t[11] = 32'hFE000000;
        load(t); frame();
        px(64, 512, 512, "R4"); px(940, 512, 512, "R4"); px(500, 300, 700, "R4");
        idle(4);

        // R9: swapped chroma columns with swapped inputs
        for (int r = 0; r < 3; r++) begin
            sw[4*r] = t[4*r]; sw[4*r+1] = t[4*r+2]; sw[4*r+2] = t[4*r+1]; sw[4*r+3] = t[4*r+3];
        end
        load(sw); frame();
        px(940, 512, 512, "R9"); px(500, 700, 300, "R9");
        idle(4);

        // R5 rounding, R6 clamping
        for (int i = 0; i < NREG; i++) t[i] = 0;
        t[0] = 32'h10000; t[5] = 32'hFFFF0000; t[7] = 32'h00000002;
        t[8] = 32'h40000; t[10] = 32'h20000;
        load(t); frame();
        px(1, 1, 0, "R5"); px(3, 3, 0, "R5"); px(2, 0, 0, "R5");
        px(1000, 0, 5, "R6"); px(0, 600, 0, "R6"); px(1023, 1023, 1023, "R6");
        idle(4);

        // R7: write without frame_start keeps the old set
        wr(0, 32'h20000);
        px(100, 1, 0, "R7");
        frame();
        px(100, 1, 0, "R7");
        idle(4);

        // R8: write together with frame_start stays pending
        wr_frame(0, 32'h30000);
        px(101, 2, 0, "R8");
        frame();
        px(101, 2, 0, "R8");
        idle(4);

        // R10: unused addresses change nothing
        wr(13, 32'hFFFFFFFF); wr(14, 32'hFFFFFFFF); wr(15, 32'hFFFFFFFF);
        frame();
        px(101, 2, 0, "R10"); px(7, 900, 3, "R10");
        idle(4);

        // R2: random sets and bursts with gaps
        for (int round = 0; round < 5; round++) begin
            for (int i = 0; i < NREG; i++) begin
                if (i % 4 == 3)
                    t[i] = {16'($urandom_range(0, 1200) - 600), 16'($urandom_range(0, 600) - 300)};
                else
                    t[i] = 32'($urandom_range(0, 1 << 20) - (1 << 19));
            end
            load(t); wr(12, (round == 2) ? 0 : 1); frame();
            for (int k = 0; k < 40; k++) begin
                if ($urandom_range(0, 3) == 0) idle(1);
                px($urandom_range(0, 1023), $urandom_range(0, 1023), $urandom_range(0, 1023), "R2");
            end
            idle(4);
        end

        idle(6);
        checks++;
        if (q_cyc.size() != 0) begin
            failures++;
            $display("FAIL R2 pending outputs got %0d exp 0", q_cyc.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule